// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block picks the two source operands that the decode stage hands on in an in-order integer pipeline. Each source register index is compared with the destination index of the instruction now in the execute stage and of the one now in the memory stage. When one of them is about to write that register, its result is used in place of the stale register-file read data. An instruction can therefore consume the result of the instruction just before it, or of the one two ahead, with no bubbles in between. This holds even though the register file is written only several cycles after execute.

A stage counts as a producer only when its valid and write-enable flags are both high. If both stages write the same register, the execute stage holds the younger instruction, so its value wins. Register 0 always reads as zero and is never forwarded. The selection is purely combinational and adds no register stage to the operand path. Each operand also reports, on a 2-bit select output, where its value came from. The register file, the ALU, stall generation and load-use detection sit outside this block.

Top module: `opnd_bypass_top`

## Requirements
- R1: When no live stage matches a nonzero source index, the operand equals the register-file read data and its select output is 2'b00.
- R2: When the execute stage is live (valid and write-enable both 1) and its destination equals a nonzero source index, the operand equals the execute result and its select output is 2'b01.
- R3: When the memory stage is live and matches a nonzero source index and the execute stage does not, the operand equals the memory result and its select output is 2'b10.
- R4: When both stages are live and match the same nonzero source index, the execute result is chosen (select 2'b01).
- R5: A source index of 0 gives operand value 0 and select 2'b11, whatever the stages or the register file present. This includes a live stage that targets register 0.
- R6: A stage whose valid or write-enable flag is 0 is never chosen, even when its destination matches.
- R7: The A and B operands are selected independently; each may take a different source in the same cycle.
- R8: Operands and selects follow their inputs combinationally, with no clock edge between a change at the inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | Source register index for operand A |
| src_b_idx | input | 5 | Source register index for operand B |
| rf_a_data | input | 64 | Register-file read data for operand A |
| rf_b_data | input | 64 | Register-file read data for operand B |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | 5 | Execute-stage destination index |
| ex_value | input | 64 | Execute-stage result |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination index |
| mem_value | input | 64 | Memory-stage result |
| opnd_a | output | 64 | Selected operand A |
| opnd_b | output | 64 | Selected operand B |
| opnd_a_src | output | 2 | Origin of A: 00 register file, 01 execute, 10 memory, 11 zero |
| opnd_b_src | output | 2 | Origin of B, same encoding |

## Verification
The block holds no state, so any fault in the compare or priority logic shows at the ports as soon as the inputs settle. The usual symptom is a wrong select code together with the register-file, older-stage or nonzero value, for the very input pattern that triggers the fault. The sweep walks every combination of a small set of indices, giving each source distinct arithmetic values so that any mis-selection changes the compared data. A priority inversion appears only when both stages match the same index. A missing liveness gate appears only when a dead stage matches. A missing zero guard appears only with index 0. The sweep covers each of these cases.

// File: rtl/opnd_bypass_pkg.sv
// Package: shared encodings for the operand bypass selector.
// Assumes stage slot 0 is the youngest producer (execute) and slot 1 the memory stage.
package opnd_bypass_pkg;

    typedef enum logic [1:0] {
        SRC_RF   = 2'b00,
        SRC_EX   = 2'b01,
        SRC_MEM  = 2'b10,
        SRC_ZERO = 2'b11
    } opnd_src_e;

    localparam int STG_EX    = 0;
    localparam int STG_MEM   = 1;
    localparam int NUM_STG   = 2;
    localparam int NUM_OPND  = 2;

endpackage

// File: rtl/opnd_hit_cmp.sv
// Module: compares one source index against every producer stage's destination.
// Assumes stg_live already combines valid and write-enable; index 0 never hits.
module opnd_hit_cmp #(
    parameter int IDX_W = 5,
    parameter int NSTG  = 2
) (
    input  logic [IDX_W-1:0]      src_idx,
    input  logic [NSTG-1:0]       stg_live,
    input  logic [NSTG*IDX_W-1:0] stg_dst,
    output logic [NSTG-1:0]       hit
);

    logic src_nonzero;

    // Purpose: register 0 is hardwired, so it is excluded from every compare.
    always_comb src_nonzero = (src_idx != '0);

    for (genvar g = 0; g < NSTG; g++) begin : g_cmp
        // Purpose: one live-and-equal compare per producer stage.
        always_comb hit[g] = stg_live[g] && src_nonzero &&
                             (stg_dst[g*IDX_W +: IDX_W] == src_idx);
    end

endmodule

// File: rtl/opnd_prio_pick.sv
// Module: fixed-priority picker; the lowest-numbered (youngest) hitting stage wins.
// Assumes stages are ordered youngest first.
module opnd_prio_pick #(
    parameter int NSTG  = 2,
    parameter int SEL_W = (NSTG > 1) ? $clog2(NSTG) : 1
) (
    input  logic [NSTG-1:0]  hit,
    output logic             any_hit,
    output logic [SEL_W-1:0] win
);

    // Purpose: scan from oldest to youngest so the youngest hit is written last.
    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        for (int i = NSTG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                win     = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/opnd_select.sv
// Module: builds one operand from register-file data or a forwarded stage result.
// Assumes the stage arrays are packed youngest first; purely combinational.
module opnd_select #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5,
    parameter int NSTG  = 2,
    parameter int SEL_W = (NSTG > 1) ? $clog2(NSTG) : 1
) (
    input  logic [IDX_W-1:0]      src_idx,
    input  logic [XLEN-1:0]       rf_data,
    input  logic [NSTG-1:0]       stg_live,
    input  logic [NSTG*IDX_W-1:0] stg_dst,
    input  logic [NSTG*XLEN-1:0]  stg_data,
    output logic [XLEN-1:0]       op_data,
    output logic                  is_zero,
    output logic                  fwd_any,
    output logic [SEL_W-1:0]      fwd_stage
);

    logic [NSTG-1:0] hit;

    opnd_hit_cmp #(.IDX_W(IDX_W), .NSTG(NSTG)) u_cmp (
        .src_idx  (src_idx),
        .stg_live (stg_live),
        .stg_dst  (stg_dst),
        .hit      (hit)
    );

    opnd_prio_pick #(.NSTG(NSTG), .SEL_W(SEL_W)) u_pick (
        .hit     (hit),
        .any_hit (fwd_any),
        .win     (fwd_stage)
    );

    // Purpose: flag the hardwired zero register.
    always_comb is_zero = (src_idx == '0);

    // Purpose: final data mux, zero first, then forwarded value, then register file.
    always_comb begin
        if (is_zero) begin
            op_data = '0;
        end else if (fwd_any) begin
            op_data = stg_data[fwd_stage*XLEN +: XLEN];
        end else begin
            op_data = rf_data;
        end
    end

endmodule

// File: rtl/opnd_bypass_top.sv
// Module: decode-stage bypass for two operands fed by execute and memory stages.
// Assumes execute is younger than memory; no clock, no storage on the operand path.
module opnd_bypass_top
    import opnd_bypass_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic [XLEN-1:0]  rf_a_data,
    input  logic [XLEN-1:0]  rf_b_data,
    input  logic             ex_valid,
    input  logic             ex_wen,
    input  logic [IDX_W-1:0] ex_dst,
    input  logic [XLEN-1:0]  ex_value,
    input  logic             mem_valid,
    input  logic             mem_wen,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic [XLEN-1:0]  mem_value,
    output logic [XLEN-1:0]  opnd_a,
    output logic [XLEN-1:0]  opnd_b,
    output logic [1:0]       opnd_a_src,
    output logic [1:0]       opnd_b_src
);

    localparam int SEL_W = (NUM_STG > 1) ? $clog2(NUM_STG) : 1;

    logic [NUM_STG-1:0]       stg_live;
    logic [NUM_STG*IDX_W-1:0] stg_dst;
    logic [NUM_STG*XLEN-1:0]  stg_data;

    logic [IDX_W-1:0] src_idx  [NUM_OPND];
    logic [XLEN-1:0]  rf_data  [NUM_OPND];
    logic [XLEN-1:0]  op_data  [NUM_OPND];
    logic             is_zero  [NUM_OPND];
    logic             fwd_any  [NUM_OPND];
    logic [SEL_W-1:0] fwd_stg  [NUM_OPND];
    opnd_src_e        src_code [NUM_OPND];

    // Purpose: a stage is a producer only when valid and writing.
    always_comb begin
        stg_live[STG_EX]  = ex_valid  & ex_wen;
        stg_live[STG_MEM] = mem_valid & mem_wen;
    end

    // Purpose: pack the producer stages, youngest in slot 0.
    always_comb begin
        stg_dst [STG_EX*IDX_W  +: IDX_W] = ex_dst;
        stg_dst [STG_MEM*IDX_W +: IDX_W] = mem_dst;
        stg_data[STG_EX*XLEN   +: XLEN]  = ex_value;
        stg_data[STG_MEM*XLEN  +: XLEN]  = mem_value;
    end

    // Purpose: gather the per-operand inputs into arrays.
    always_comb begin
        src_idx[0] = src_a_idx;
        src_idx[1] = src_b_idx;
        rf_data[0] = rf_a_data;
        rf_data[1] = rf_b_data;
    end

    for (genvar o = 0; o < NUM_OPND; o++) begin : g_opnd
        opnd_select #(
            .XLEN  (XLEN),
            .IDX_W (IDX_W),
            .NSTG  (NUM_STG),
            .SEL_W (SEL_W)
        ) u_sel (
            .src_idx   (src_idx[o]),
            .rf_data   (rf_data[o]),
            .stg_live  (stg_live),
            .stg_dst   (stg_dst),
            .stg_data  (stg_data),
            .op_data   (op_data[o]),
            .is_zero   (is_zero[o]),
            .fwd_any   (fwd_any[o]),
            .fwd_stage (fwd_stg[o])
        );

        // Purpose: turn the picker result into the external origin code.
        always_comb begin
            if (is_zero[o]) begin
                src_code[o] = SRC_ZERO;
            end else if (fwd_any[o]) begin
                src_code[o] = (int'(fwd_stg[o]) == STG_EX) ? SRC_EX : SRC_MEM;
            end else begin
                src_code[o] = SRC_RF;
            end
        end
    end

    // Purpose: drive the output ports.
    always_comb begin
        opnd_a     = op_data[0];
        opnd_b     = op_data[1];
        opnd_a_src = src_code[0];
        opnd_b_src = src_code[1];
    end

endmodule

// File: rtl/opnd_bypass_chk.sv
// Checker: port-level consistency of the bypass selection (operand A and B).
// Assumes combinational behaviour; checks are skipped while any input is unknown.
module opnd_bypass_chk #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input logic [IDX_W-1:0] src_a_idx,
    input logic [IDX_W-1:0] src_b_idx,
    input logic [XLEN-1:0]  rf_a_data,
    input logic [XLEN-1:0]  rf_b_data,
    input logic             ex_valid,
    input logic             ex_wen,
    input logic [IDX_W-1:0] ex_dst,
    input logic [XLEN-1:0]  ex_value,
    input logic             mem_valid,
    input logic             mem_wen,
    input logic [IDX_W-1:0] mem_dst,
    input logic [XLEN-1:0]  mem_value,
    input logic [XLEN-1:0]  opnd_a,
    input logic [XLEN-1:0]  opnd_b,
    input logic [1:0]       opnd_a_src,
    input logic [1:0]       opnd_b_src
);

    logic known;
    logic ex_hit_a;
    logic ex_hit_b;

    // Purpose: only judge fully known input and output patterns.
    always_comb known = !$isunknown({src_a_idx, src_b_idx, rf_a_data, rf_b_data,
                                     ex_valid, ex_wen, ex_dst, ex_value,
                                     mem_valid, mem_wen, mem_dst, mem_value,
                                     opnd_a, opnd_b, opnd_a_src, opnd_b_src});

    // Purpose: reference match of the execute stage for each operand.
    always_comb begin
        ex_hit_a = ex_valid && ex_wen && (ex_dst == src_a_idx) && (src_a_idx != '0);
        ex_hit_b = ex_valid && ex_wen && (ex_dst == src_b_idx) && (src_b_idx != '0);
    end

    // Purpose: immediate checks on every settled input pattern.
    always_comb begin
        if (known) begin
            AST_ZERO_SRC_A: assert (src_a_idx != '0 || (opnd_a == '0 && opnd_a_src == 2'b11)) else $error("zero index A"); // R5
            AST_ZERO_SRC_B: assert (src_b_idx != '0 || (opnd_b == '0 && opnd_b_src == 2'b11)) else $error("zero index B"); // R5
            AST_EX_WINS_A: assert (!ex_hit_a || (opnd_a == ex_value && opnd_a_src == 2'b01)) else $error("ex priority A"); // R4
            AST_EX_WINS_B: assert (!ex_hit_b || (opnd_b == ex_value && opnd_b_src == 2'b01)) else $error("ex priority B"); // R4
            AST_DEAD_EX: assert (opnd_a_src != 2'b01 || (ex_valid && ex_wen)) else $error("dead ex chosen"); // R6
            AST_DEAD_MEM: assert (opnd_a_src != 2'b10 || (mem_valid && mem_wen && !ex_hit_a)) else $error("bad mem pick"); // R3
            AST_RF_PASS: assert (opnd_a_src != 2'b00 || opnd_a == rf_a_data) else $error("rf data A"); // R1
        end
    end

endmodule

bind opnd_bypass_top opnd_bypass_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_opnd_bypass_top.sv
// Bench: near-exhaustive sweep over small indices plus pipeline-style scenarios.
module sim_opnd_bypass_top;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 64;
    localparam int IDX_W      = 5;
    localparam int WDOG_LIMIT = 100000;

    logic clk = 1'b0;
    logic [IDX_W-1:0] src_a_idx, src_b_idx, ex_dst, mem_dst;
    logic [XLEN-1:0]  rf_a_data, rf_b_data, ex_value, mem_value;
    logic             ex_valid, ex_wen, mem_valid, mem_wen;
    logic [XLEN-1:0]  opnd_a, opnd_b;
    logic [1:0]       opnd_a_src, opnd_b_src;

    int n_cmp  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_bypass_top #(.XLEN(XLEN), .IDX_W(IDX_W)) u0 (.*);

    // Purpose: watchdog that ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WDOG_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference per requirements: returns {origin code, value} and a requirement tag.
    task automatic expect_op(input logic [IDX_W-1:0] idx, input logic [XLEN-1:0] rf,
                             output logic [1:0] code, output logic [XLEN-1:0] val,
                             output string tag);
        bit exl, meml, exm, memm;
        exl  = ex_valid && ex_wen;
        meml = mem_valid && mem_wen;
        exm  = (ex_dst == idx);
        memm = (mem_dst == idx);
        if (idx == 0) begin
            code = 2'b11; val = '0; tag = "R5";
        end else if (exl && exm) begin
            code = 2'b01; val = ex_value; tag = (meml && memm) ? "R4" : "R2";
        end else if (meml && memm) begin
            code = 2'b10; val = mem_value; tag = "R3";
        end else begin
            code = 2'b00; val = rf;
            tag = (exm || memm) ? "R6" : "R1";
        end
    endtask

    task automatic check_both(input string pre);
        logic [1:0] c; logic [XLEN-1:0] v; string t;
        expect_op(src_a_idx, rf_a_data, c, v, t);
        chk({pre, t, " A data"}, opnd_a, v);
        chk({pre, t, " A src"}, {62'd0, opnd_a_src}, {62'd0, c});
        expect_op(src_b_idx, rf_b_data, c, v, t);
        chk({pre, t, " B data"}, opnd_b, v);
        chk({pre, t, " B src"}, {62'd0, opnd_b_src}, {62'd0, c});
    endtask

    task automatic idle_stages();
        ex_valid = 0; ex_wen = 0; ex_dst = 0; ex_value = 0;
        mem_valid = 0; mem_wen = 0; mem_dst = 0; mem_value = 0;
    endtask

    initial begin
        src_a_idx = 0; src_b_idx = 0; rf_a_data = 0; rf_b_data = 0;
        idle_stages();
        @(negedge clk);
        // Idle state: index 0 on both operands (R5).
        chk("R5 idle A src", {62'd0, opnd_a_src}, 64'd3);
        chk("R5 idle B data", opnd_b, 64'd0);

        // Scenario: back-to-back dependent adds, value from execute (R2).
        @(posedge clk);
        idle_stages();
        ex_valid = 1; ex_wen = 1; ex_dst = 1; ex_value = 64'd256;
        src_a_idx = 1; src_b_idx = 3; rf_a_data = 64'd7; rf_b_data = 64'd9;
        @(negedge clk);
        chk("R2 back-to-back", opnd_a, 64'd256);
        chk("R1 unrelated B", opnd_b, 64'd9);

        // Scenario: dependency two apart, value from memory (R3).
        @(posedge clk);
        mem_valid = 1; mem_wen = 1; mem_dst = 1; mem_value = 64'd256;
        ex_dst = 4; ex_value = 64'd11;
        @(negedge clk);
        chk("R3 two apart", opnd_a, 64'd256);

        // Scenario: same destination overwrite, younger wins (R4).
        @(posedge clk);
        ex_dst = 1; ex_value = 64'd512;
        @(negedge clk);
        chk("R4 overwrite", opnd_a, 64'd512);

        // Scenario: live writes to register 0 have no effect (R5).
        @(posedge clk);
        ex_dst = 0; ex_value = 64'hDEAD; mem_dst = 0; mem_value = 64'hBEEF;
        src_a_idx = 0; src_b_idx = 1; rf_b_data = 64'd33;
        @(negedge clk);
        chk("R5 x0 write A", opnd_a, 64'd0);
        chk("R5 x0 write B untouched", opnd_b, 64'd33);

        // Independence: A from execute, B from memory in the same cycle (R7).
        @(posedge clk);
        ex_dst = 2; ex_value = 64'd100; mem_dst = 5; mem_value = 64'd200;
        src_a_idx = 2; src_b_idx = 5;
        @(negedge clk);
        chk("R7 A from ex", {62'd0, opnd_a_src}, 64'd1);
        chk("R7 B from mem", {62'd0, opnd_b_src}, 64'd2);

        // Combinational path: outputs follow inputs with no clock edge (R8).
        ex_value = 64'd123;
        #1;
        chk("R8 no edge", opnd_a, 64'd123);

        // Sweep over small indices and all liveness flag patterns (R1..R6).
        for (int n = 0; n < 4096; n++) begin
            @(posedge clk);
            src_a_idx = IDX_W'(n[1:0]);
            src_b_idx = IDX_W'(n[3:2]);
            ex_dst    = IDX_W'(n[5:4]);
            mem_dst   = IDX_W'(n[7:6]);
            ex_valid  = n[8];  ex_wen  = n[9];
            mem_valid = n[10]; mem_wen = n[11];
            rf_a_data = 64'h1111_0000_0000_0000 + 64'(n);
            rf_b_data = 64'h2222_0000_0000_0000 + 64'(n);
            ex_value  = 64'hEEEE_0000_0000_0000 + 64'(n);
            mem_value = 64'h4444_0000_0000_0000 + 64'(n);
            @(negedge clk);
            check_both("sweep ");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule